// File: doc/BRIEF.md
# CAN Error Status Unit

This unit keeps the error bookkeeping of a CAN controller core. A protocol engine, not part of the unit, sends it single-cycle strobes: a last-error code, a successful receive, a successful transmit, a transmit error and a receive error. From these strobes the unit maintains a transmit error count, a receive error count and a receive-passive flag. It derives the warning, passive and bus-off states from them and latches the most recent error code where the host can read it.

A small host port reaches three word-wide registers: control, status and error count. The host can load the value 7 into the error-code field. Since 7 is never a real event, any later real code stands out from a stale one. Two interrupt sources drive a single interrupt line. One is status events: a new error code or a successful frame. The other is any change of the warning, passive or bus-off state. Each source has its own enable, and a module enable gates the line.

When the transmit count would pass 255, the node goes bus-off and the unit sets the init bit in control. While init is set, the unit ignores every protocol strobe. If the host clears init while bus-off, the counters are zeroed and the node returns to error-active.

Top module: `can_esr`

## Requirements
- R1: After reset, control reads 0x0001 (init set, all enables clear), status and error count read 0, and the state flags and interrupt are low.
- R2: Address 0 is control, with bit 0 init, bit 1 module interrupt enable, bit 2 status interrupt enable and bit 3 error interrupt enable. Address 1 is status, with bits 2:0 error code, bit 3 TXOK, bit 4 RXOK, bit 5 passive, bit 6 warning and bit 7 bus-off. Address 2 is error count, with bits 7:0 the transmit count, bits 14:8 the receive count and bit 15 the receive-passive flag. Address 3 reads 0, and unlisted bits read 0.
- R3: A code strobe loads the error-code field with the strobed value. A host write to status loads that field from write bits 2:0 and changes no other status bit.
- R4: A receive-OK or transmit-OK strobe sets RXOK or TXOK. A host read of status returns the bits and clears both on the same clock edge.
- R5: A transmit error adds 8 to the transmit count. A transmit-OK subtracts 1 and stops at 0. When both arrive in the same cycle, the error wins.
- R6: A receive error adds 1 to the receive count, up to 127. At 127 it sets the receive-passive flag instead. A receive-OK clears that flag if it is set; otherwise it subtracts 1 from the count, stopping at 0. When both arrive in the same cycle, the error wins.
- R7: The warning flag is high when either count is 96 or more. The passive flag is high when the transmit count exceeds 127 or the receive-passive flag is set.
- R8: A transmit error that would take the count above 255 sets bus-off, leaves the count unchanged and sets init.
- R9: A host write to control with bit 0 clear while bus-off zeroes both counts and the receive-passive flag, and clears bus-off.
- R10: While init is set, the unit ignores all protocol strobes: the counts, the error code, RXOK and TXOK do not change and no status interrupt is raised.
- R11: With the status interrupt enabled, a status event is pending after the edge that samples either of two things. The first is a code strobe whose code is not 7 and differs from the stored code. The second is a receive-OK or transmit-OK strobe. The interrupt line equals the module enable AND (status event pending OR error event pending).
- R12: With the error interrupt enabled, an error event is pending one edge after the warning, passive or bus-off flag changes in either direction.
- R13: A host read of status clears both pending events. An event that arrives in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pe_lec_valid | input | 1 | Error-code strobe from the protocol engine |
| pe_lec_code | input | 3 | Error code carried by the strobe |
| pe_rx_ok | input | 1 | Frame received successfully |
| pe_tx_ok | input | 1 | Frame transmitted successfully |
| pe_rx_err | input | 1 | Receive error detected |
| pe_tx_err | input | 1 | Transmit error detected |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects on status) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register read data, combinational from address |
| err_warn | output | 1 | Warning state |
| err_passive | output | 1 | Error-passive state |
| bus_off | output | 1 | Bus-off state |
| stat_irq | output | 1 | Interrupt line |

## Verification
Each strobe or host write is sampled on one rising edge. Its effect on the counts, the status bits, the state flags and a status event is visible right after that edge. An error event follows one edge later, because state changes are compared against a registered copy of the flags. Read data is combinational from the address, so a status read returns the bits as they stood before the edge that clears them. The bench applies inputs at falling edges and advances a requirement model on the same rising edge the design uses. It then compares every register, flag and the interrupt line at the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/can_esr_pkg.sv
package can_esr_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_ECNT = 2'd2;

    typedef enum logic [2:0] {
        LEC_NONE    = 3'd0,
        LEC_STUFF   = 3'd1,
        LEC_FORM    = 3'd2,
        LEC_ACK     = 3'd3,
        LEC_BIT_REC = 3'd4,
        LEC_BIT_DOM = 3'd5,
        LEC_CRC     = 3'd6,
        LEC_IDLE    = 3'd7
    } lec_e;

    // bit 3 down to bit 0 of the control word
    typedef struct packed {
        logic err_ie;
        logic stat_ie;
        logic mod_ie;
        logic init;
    } ctrl_t;

endpackage

// File: rtl/can_esr_counters.sv
module can_esr_counters #(
    parameter int unsigned TEC_W   = 8,
    parameter int unsigned REC_W   = 7,
    parameter int unsigned TX_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             recover_i,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_err_i,
    input  logic             rx_ok_i,
    output logic [TEC_W-1:0] tec_o,
    output logic [REC_W-1:0] rec_o,
    output logic             rp_o,
    output logic             bus_off_o,
    output logic             boff_enter_o
);

    localparam logic [TEC_W:0]   TEC_LIMIT = (TEC_W+1)'((2**TEC_W) - 1);
    localparam logic [TEC_W:0]   TEC_STEP  = (TEC_W+1)'(TX_STEP);
    localparam logic [TEC_W-1:0] TEC_ONE   = 1;
    localparam logic [REC_W-1:0] REC_ONE   = 1;
    localparam logic [REC_W-1:0] REC_MAX   = '1;

    typedef struct packed {
        logic [TEC_W-1:0] tec;
        logic [REC_W-1:0] rec;
        logic             rp;
        logic             boff;
    } cnt_t;

    cnt_t        cnt_d, cnt_q;
    logic        enter_d;
    logic [TEC_W:0] tec_sum;

    always_comb begin
        cnt_d   = cnt_q;
        enter_d = 1'b0;
        tec_sum = {1'b0, cnt_q.tec} + TEC_STEP;
        if (recover_i) begin
            cnt_d = '0;
        end else if (!hold_i) begin
            if (tx_err_i) begin
                if (tec_sum > TEC_LIMIT) begin
                    cnt_d.boff = 1'b1;
                    enter_d    = 1'b1;
                end else begin
                    cnt_d.tec = tec_sum[TEC_W-1:0];
                end
            end else if (tx_ok_i && cnt_q.tec != '0) begin
                cnt_d.tec = cnt_q.tec - TEC_ONE;
            end
            if (rx_err_i) begin
                if (cnt_q.rec == REC_MAX) cnt_d.rp  = 1'b1;
                else                      cnt_d.rec = cnt_q.rec + REC_ONE;
            end else if (rx_ok_i) begin
                if (cnt_q.rp)                 cnt_d.rp  = 1'b0;
                else if (cnt_q.rec != '0)     cnt_d.rec = cnt_q.rec - REC_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tec_o        = cnt_q.tec;
    assign rec_o        = cnt_q.rec;
    assign rp_o         = cnt_q.rp;
    assign bus_off_o    = cnt_q.boff;
    assign boff_enter_o = enter_d;

    // R6: the receive-passive flag only exists with the count at its ceiling
    a_r6_rp_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        rp_o |-> (rec_o == REC_MAX));

    // R8: bus-off only with a count one step short of overflow
    a_r8_boff_tec_high: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off_o |-> ({1'b0, tec_o} + TEC_STEP > TEC_LIMIT));

    // R10: held counters stay put
    a_r10_hold_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !recover_i) |=> ($stable(tec_o) && $stable(rec_o) && $stable(rp_o)));

    // R5: an accepted transmit error moves the count by one step
    a_r5_tec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !recover_i && tx_err_i && !boff_enter_o)
        |=> (tec_o == $past(tec_o) + TEC_STEP[TEC_W-1:0]));

endmodule

// File: rtl/can_esr_levels.sv
module can_esr_levels #(
    parameter int unsigned TEC_W    = 8,
    parameter int unsigned REC_W    = 7,
    parameter int unsigned WARN_LVL = 96,
    parameter int unsigned PASS_LVL = 128
) (
    input  logic [TEC_W-1:0] tec_i,
    input  logic [REC_W-1:0] rec_i,
    input  logic             rp_i,
    output logic             warn_o,
    output logic             passive_o
);

    localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LVL);
    localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LVL);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASS_LVL);

    always_comb begin
        warn_o    = (tec_i >= TEC_WARN) || (rec_i >= REC_WARN);
        passive_o = (tec_i >= TEC_PASS) || rp_i;
    end

endmodule

// File: rtl/can_esr.sv
module can_esr
    import can_esr_pkg::*;
#(
    parameter int unsigned TEC_W    = 8,
    parameter int unsigned REC_W    = 7,
    parameter int unsigned TX_STEP  = 8,
    parameter int unsigned WARN_LVL = 96,
    parameter int unsigned PASS_LVL = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pe_lec_valid,
    input  logic [2:0]        pe_lec_code,
    input  logic              pe_rx_ok,
    input  logic              pe_tx_ok,
    input  logic              pe_rx_err,
    input  logic              pe_tx_err,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    output logic              err_warn,
    output logic              err_passive,
    output logic              bus_off,
    output logic              stat_irq
);

    localparam int unsigned CNT_BITS = TEC_W + REC_W + 1;

    typedef struct packed {
        ctrl_t      ctrl;
        logic [2:0] lec;
        logic       rxok;
        logic       txok;
        logic       sts_pend;
        logic       err_pend;
        logic [2:0] flags_prev;
    } st_t;

    st_t              st_d, st_q;
    logic [TEC_W-1:0] tec;
    logic [REC_W-1:0] rec;
    logic             rp, boff_enter, recover;
    logic             stat_rd, ctrl_wr, stat_wr, stat_evt;
    logic [2:0]       flags;
    logic             unused_wbits;

    assign unused_wbits = ^host_wdata[REG_W-1:4];

    assign ctrl_wr = host_wr && (host_addr == ADDR_CTRL);
    assign stat_wr = host_wr && (host_addr == ADDR_STAT);
    assign stat_rd = host_rd && (host_addr == ADDR_STAT);
    assign recover = ctrl_wr && !host_wdata[0] && bus_off;

    can_esr_counters #(.TEC_W(TEC_W), .REC_W(REC_W), .TX_STEP(TX_STEP)) u_counters (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_i       (st_q.ctrl.init),
        .recover_i    (recover),
        .tx_err_i     (pe_tx_err),
        .tx_ok_i      (pe_tx_ok),
        .rx_err_i     (pe_rx_err),
        .rx_ok_i      (pe_rx_ok),
        .tec_o        (tec),
        .rec_o        (rec),
        .rp_o         (rp),
        .bus_off_o    (bus_off),
        .boff_enter_o (boff_enter)
    );

    can_esr_levels #(.TEC_W(TEC_W), .REC_W(REC_W), .WARN_LVL(WARN_LVL),
                     .PASS_LVL(PASS_LVL)) u_levels (
        .tec_i     (tec),
        .rec_i     (rec),
        .rp_i      (rp),
        .warn_o    (err_warn),
        .passive_o (err_passive)
    );

    assign flags    = {bus_off, err_warn, err_passive};
    assign stat_evt = (pe_lec_valid && (pe_lec_code != LEC_IDLE) && (pe_lec_code != st_q.lec))
                      || pe_rx_ok || pe_tx_ok;

    always_comb begin
        st_d = st_q;
        if (stat_rd) begin
            st_d.rxok     = 1'b0;
            st_d.txok     = 1'b0;
            st_d.sts_pend = 1'b0;
            st_d.err_pend = 1'b0;
        end
        if (ctrl_wr) st_d.ctrl = ctrl_t'(host_wdata[3:0]);
        if (stat_wr) st_d.lec  = host_wdata[2:0];
        if (!st_q.ctrl.init) begin
            if (pe_lec_valid) st_d.lec  = pe_lec_code;
            if (pe_rx_ok)     st_d.rxok = 1'b1;
            if (pe_tx_ok)     st_d.txok = 1'b1;
            if (st_q.ctrl.stat_ie && stat_evt) st_d.sts_pend = 1'b1;
        end
        if (st_q.ctrl.err_ie && (flags != st_q.flags_prev)) st_d.err_pend = 1'b1;
        st_d.flags_prev = flags;
        if (boff_enter) st_d.ctrl.init = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ctrl.init <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADDR_CTRL: host_rdata[3:0] = st_q.ctrl;
            ADDR_STAT: host_rdata[7:0] = {bus_off, err_warn, err_passive,
                                          st_q.rxok, st_q.txok, st_q.lec};
            ADDR_ECNT: host_rdata[CNT_BITS-1:0] = {rp, rec, tec};
            default:   host_rdata = '0;
        endcase
    end

    assign stat_irq = st_q.ctrl.mod_ie && (st_q.sts_pend || st_q.err_pend);

    // R13: a status read with no new event leaves nothing pending
    a_r13_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(st_q.ctrl.err_ie && flags != st_q.flags_prev)
         && (st_q.ctrl.init || !st_q.ctrl.stat_ie || !stat_evt))
        |=> (!st_q.sts_pend && !st_q.err_pend));

    // R11: a status event only becomes pending with its enable set
    a_r11_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sts_pend) |-> $past(st_q.ctrl.stat_ie));

    // R10: the code field is frozen in init unless the host writes it
    a_r10_lec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.init && !stat_wr) |=> $stable(st_q.lec));

    // R4: reading status drops RXOK when no receive-OK arrives
    a_r4_rxok_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !pe_rx_ok) |=> !st_q.rxok);

    // R8: entering bus-off always leaves init set
    a_r8_init_on_boff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |-> st_q.ctrl.init);

endmodule

// File: tb/test_can_esr.sv
module test_can_esr;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pe_lec_valid = 1'b0;
    logic [2:0]  pe_lec_code = 3'd0;
    logic        pe_rx_ok = 1'b0, pe_tx_ok = 1'b0, pe_rx_err = 1'b0, pe_tx_err = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        err_warn, err_passive, bus_off, stat_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // requirement model
    int       m_tec = 0, m_rec = 0;
    bit       m_rp = 0, m_boff = 0;
    bit [3:0] m_ctrl = 4'b0001;
    bit [2:0] m_lec = 0;
    bit       m_rxok = 0, m_txok = 0, m_sp = 0, m_ep = 0;
    bit [2:0] m_fprev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_esr i_can_esr (
        .clk(clk), .rst_n(rst_n),
        .pe_lec_valid(pe_lec_valid), .pe_lec_code(pe_lec_code),
        .pe_rx_ok(pe_rx_ok), .pe_tx_ok(pe_tx_ok),
        .pe_rx_err(pe_rx_err), .pe_tx_err(pe_tx_err),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .err_warn(err_warn), .err_passive(err_passive),
        .bus_off(bus_off), .stat_irq(stat_irq)
    );

    function automatic bit m_warn();
        return (m_tec >= 96) || (m_rec >= 96);
    endfunction

    function automatic bit m_pass();
        return (m_tec > 127) || m_rp;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // advance the model on the same rising edge the design samples
    task automatic model_edge();
        bit [2:0] fl = {m_boff, m_warn(), m_pass()};
        bit init = m_ctrl[0];
        bit enter = 0;
        int ntec = m_tec, nrec = m_rec;
        bit nrp = m_rp, nboff = m_boff;
        bit [3:0] nctrl = m_ctrl;
        bit [2:0] nlec = m_lec;
        bit nrx = m_rxok, ntx = m_txok, nsp = m_sp, nep = m_ep;
        if (host_rd && host_addr == 2'd1) begin
            nrx = 0; ntx = 0; nsp = 0; nep = 0;
        end
        if (host_wr && host_addr == 2'd0) nctrl = host_wdata[3:0];
        if (host_wr && host_addr == 2'd1) nlec = host_wdata[2:0];
        if (host_wr && host_addr == 2'd0 && !host_wdata[0] && m_boff) begin
            ntec = 0; nrec = 0; nrp = 0; nboff = 0;
        end else if (!init) begin
            if (pe_tx_err) begin
                if (m_tec + 8 > 255) begin nboff = 1; enter = 1; end
                else ntec = m_tec + 8;
            end else if (pe_tx_ok && m_tec > 0) ntec = m_tec - 1;
            if (pe_rx_err) begin
                if (m_rec == 127) nrp = 1; else nrec = m_rec + 1;
            end else if (pe_rx_ok) begin
                if (m_rp) nrp = 0; else if (m_rec > 0) nrec = m_rec - 1;
            end
        end
        if (!init) begin
            if (m_ctrl[2] && ((pe_lec_valid && pe_lec_code != 3'd7 && pe_lec_code != m_lec)
                              || pe_rx_ok || pe_tx_ok)) nsp = 1;
            if (pe_lec_valid) nlec = pe_lec_code;
            if (pe_rx_ok) nrx = 1;
            if (pe_tx_ok) ntx = 1;
        end
        if (m_ctrl[3] && fl != m_fprev) nep = 1;
        m_fprev = fl;
        if (enter) nctrl[0] = 1;
        m_tec = ntec; m_rec = nrec; m_rp = nrp; m_boff = nboff;
        m_ctrl = nctrl; m_lec = nlec; m_rxok = nrx; m_txok = ntx;
        m_sp = nsp; m_ep = nep;
    endtask

    // compare every register and output without side effects (read strobe low)
    task automatic check_all(string tag);
        logic [1:0] save = host_addr;
        host_addr = 2'd0; #1;
        chk(tag, "control", int'(host_rdata), int'({12'd0, m_ctrl}));
        host_addr = 2'd1; #1;
        chk(tag, "status", int'(host_rdata),
            int'({8'd0, m_boff, m_warn(), m_pass(), m_rxok, m_txok, m_lec}));
        host_addr = 2'd2; #1;
        chk(tag, "errcount", int'(host_rdata), (int'(m_rp) << 15) | (m_rec << 8) | m_tec);
        chk(tag, "err_warn", int'(err_warn), int'(m_warn()));
        chk(tag, "err_passive", int'(err_passive), int'(m_pass()));
        chk(tag, "bus_off", int'(bus_off), int'(m_boff));
        chk(tag, "stat_irq", int'(stat_irq), int'(m_ctrl[1] & (m_sp | m_ep)));
        host_addr = save;
    endtask

    // inputs are set at a falling edge; one rising edge; check at next falling edge
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        pe_lec_valid = 0; pe_rx_ok = 0; pe_tx_ok = 0; pe_rx_err = 0; pe_tx_err = 0;
        host_wr = 0; host_rd = 0;
        check_all(tag);
    endtask

    task automatic strobe(bit lv, bit [2:0] code, bit rxo, bit txo, bit rxe, bit txe, string tag);
        pe_lec_valid = lv; pe_lec_code = code;
        pe_rx_ok = rxo; pe_tx_ok = txo; pe_rx_err = rxe; pe_tx_err = txe;
        step(tag);
    endtask

    task automatic hwrite(bit [1:0] a, bit [15:0] d, string tag);
        host_wr = 1; host_addr = a; host_wdata = d;
        step(tag);
    endtask

    task automatic hread_status(string tag);
        host_addr = 2'd1; #1;
        chk(tag, "status before clear", int'(host_rdata),
            int'({8'd0, m_boff, m_warn(), m_pass(), m_rxok, m_txok, m_lec}));
        host_rd = 1;
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");
        host_addr = 2'd3; #1;
        chk("R2", "unused address", int'(host_rdata), 0);

        // R10: strobes at reset (init set) are ignored
        strobe(1, 3'd4, 1, 1, 1, 1, "R10");

        hwrite(2'd0, 16'h000E, "R2");
        hwrite(2'd1, 16'hFFFF, "R3");          // sentinel, other bits untouched

        // R11: sweep every code after the sentinel
        for (int c = 0; c < 8; c++) begin
            strobe(1, 3'(c), 0, 0, 0, 0, "R11");
            hread_status("R13");
            hwrite(2'd1, 16'h0007, "R3");
        end
        // R11: repeated code without sentinel raises nothing
        strobe(1, 3'd3, 0, 0, 0, 0, "R11");
        hread_status("R13");
        strobe(1, 3'd3, 0, 0, 0, 0, "R11");
        hwrite(2'd1, 16'hFFF5, "R3");

        // R4: ok bits and read-clear
        strobe(0, 0, 1, 0, 0, 0, "R4");
        strobe(0, 0, 0, 1, 0, 0, "R4");
        hread_status("R4");
        hread_status("R4");

        // R11: status enable off
        hwrite(2'd0, 16'h000A, "R11");
        strobe(1, 3'd2, 1, 0, 0, 0, "R11");
        hread_status("R13");
        hwrite(2'd0, 16'h000E, "R2");

        // R5, R7, R8, R12: transmit count sweep into bus-off
        for (int n = 0; n < 32; n++) begin
            strobe(0, 0, 0, 0, 0, 1, (n == 31) ? "R8" : "R5");
            step("R12");
            hread_status("R7");
        end

        // R10: everything ignored while bus-off holds init
        strobe(1, 3'd1, 0, 0, 0, 0, "R10");
        strobe(0, 0, 1, 1, 1, 1, "R10");
        strobe(0, 0, 0, 1, 0, 0, "R10");

        // R9: recovery
        hwrite(2'd0, 16'h000E, "R9");
        step("R12");
        hread_status("R13");

        // R5: decrement, precedence, floor
        strobe(0, 0, 0, 0, 0, 1, "R5");
        strobe(0, 0, 0, 0, 0, 1, "R5");
        strobe(0, 0, 0, 1, 0, 0, "R5");
        strobe(0, 0, 0, 1, 0, 1, "R5");
        for (int n = 0; n < 24; n++) strobe(0, 0, 0, 1, 0, 0, "R5");
        hread_status("R13");

        // R6, R7: receive count sweep past the ceiling
        for (int n = 0; n < 129; n++) strobe(0, 0, 0, 0, 1, 0, "R6");
        strobe(0, 0, 1, 0, 1, 0, "R6");
        strobe(0, 0, 1, 0, 0, 0, "R6");
        strobe(0, 0, 1, 0, 0, 0, "R6");
        hread_status("R13");
        step("R12");
        hread_status("R13");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule